// File: doc/BRIEF.md
# Retriggerable Trigger Gate Generator

This block turns trigger events into a timed gate. A set of trigger lines is qualified by a per-line enable mask, and the enabled lines are ORed together. The rising edge of that OR is the trigger. A trigger that arrives while the block is idle starts a tick counter. The gate opens when the counter reaches the programmed start value. It closes when the counter reaches the programmed stop value, and the block then goes back to idle. Both values count clock ticks from the moment the block leaves idle.

An inversion option sets the polarity of the gate output. A retrigger option makes any new trigger that arrives while the block is busy reload the counter to the start value, which holds the gate open for a further stop − start ticks. All configuration inputs are treated as static registers. The start value, the stop value and the retrigger option are captured at the moment the block leaves idle.

Top module: `gate_gen`

## Requirements
- R1: While rst_ni is low, and after reset until a trigger arrives, gate_o equals negate_i, which is the inactive level.
- R2: Only trigger lines whose bit in src_mask_i is 1 can start a gate. Activity on a line whose mask bit is 0 leaves gate_o at the inactive level.
- R3: A trigger is the 0-to-1 transition of the masked OR, sampled on each rising clock edge. A line held high produces exactly one trigger.
- R4: If the trigger is sampled at edge k and start < stop, the gate is active after edge k+t for every t with start ≤ t < stop, and inactive for all other t. This gives a pulse of stop − start cycles.
- R5: With start = 0, the gate becomes active in the cycle directly after the edge that samples the trigger.
- R6: If start ≥ stop when a trigger is sampled in idle, no gate pulse is produced and the block stays idle.
- R7: With retrigger disabled, triggers that arrive while the block is not idle have no effect on gate_o.
- R8: With retrigger enabled, a trigger sampled at edge r while the block is not idle makes the gate active after edge r and keeps it active until edge r + stop − start. This also applies when the trigger arrives before the gate has opened.
- R9: When negate_i = 1, gate_o is the bitwise inverse of the active-high gate.
- R10: Changes to start_i, stop_i and retrig_en_i while the block is not idle do not change the pulse in progress.
- R11: After the gate closes, the block is idle and a new trigger starts a new pulse with the same timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Tick clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | N_SRC | Trigger lines, synchronous to clk_i |
| src_mask_i | input | N_SRC | Per-line trigger enable |
| start_i | input | CNT_W | Ticks from leaving idle to gate open |
| stop_i | input | CNT_W | Ticks from leaving idle to gate close |
| negate_i | input | 1 | Invert gate polarity |
| retrig_en_i | input | 1 | Reload counter to start on a trigger while busy |
| gate_o | output | 1 | Gate output |

## Verification
Single triggers are swept over every start/stop pair up to small limits with both polarities. This separates an off-by-one error at the opening edge from one at the closing edge, and it covers the zero-start and empty-window cases. A second trigger is then injected at every offset within the window, with retrigger both on and off. This shows the difference between a reload to start and a reload to zero, and it shows whether late triggers are ignored when retrigger is off. Further runs drive only masked-off lines, hold a line high for the whole window, and change the configuration mid-pulse. These isolate the mask, the edge qualification and the capture of configuration on leaving idle.

// File: rtl/gate_pkg.sv
package gate_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DELAY  = 2'd1,
    ST_ACTIVE = 2'd2
  } gate_state_e;
endpackage

// File: rtl/gate_trig_edge.sv
module gate_trig_edge #(
  parameter int N_SRC = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] trig_i,
  input  logic [N_SRC-1:0] mask_i,
  output logic             pulse_o
);
  logic any_now, any_q;

  assign any_now = |(trig_i & mask_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) any_q <= 1'b0;
    else         any_q <= any_now;
  end

  assign pulse_o = any_now & ~any_q;
endmodule

// File: rtl/gate_timer.sv
module gate_timer
  import gate_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pulse_i,
  input  logic [CNT_W-1:0] start_i,
  input  logic [CNT_W-1:0] stop_i,
  input  logic             retrig_en_i,
  output logic             active_o,
  output gate_state_e      state_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] start_q_o,
  output logic [CNT_W-1:0] stop_q_o,
  output logic             retrig_q_o
);
  gate_state_e      state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic [CNT_W-1:0] start_q, start_d, stop_q, stop_d;
  logic             retrig_q, retrig_d;

  assign cnt_inc = cnt_q + 1'b1;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    start_d  = start_q;
    stop_d   = stop_q;
    retrig_d = retrig_q;
    unique case (state_q)
      ST_IDLE: begin
        // empty or inverted window: no pulse, stay idle
        if (pulse_i && (start_i < stop_i)) begin
          start_d  = start_i;
          stop_d   = stop_i;
          retrig_d = retrig_en_i;
          cnt_d    = '0;
          state_d  = (start_i == '0) ? ST_ACTIVE : ST_DELAY;
        end
      end
      ST_DELAY: begin
        if (retrig_q && pulse_i) begin
          cnt_d   = start_q;
          state_d = ST_ACTIVE;
        end else begin
          cnt_d = cnt_inc;
          if (cnt_inc == start_q) state_d = ST_ACTIVE;
        end
      end
      ST_ACTIVE: begin
        if (retrig_q && pulse_i) begin
          cnt_d = start_q;
        end else if (cnt_inc == stop_q) begin
          cnt_d   = '0;
          state_d = ST_IDLE;
        end else begin
          cnt_d = cnt_inc;
        end
      end
      default: begin
        cnt_d   = '0;
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      start_q  <= '0;
      stop_q   <= '0;
      retrig_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      start_q  <= start_d;
      stop_q   <= stop_d;
      retrig_q <= retrig_d;
    end
  end

  assign active_o   = (state_q == ST_ACTIVE);
  assign state_o    = state_q;
  assign cnt_o      = cnt_q;
  assign start_q_o  = start_q;
  assign stop_q_o   = stop_q;
  assign retrig_q_o = retrig_q;
endmodule

// File: rtl/gate_gen.sv
module gate_gen
  import gate_pkg::*;
#(
  parameter int N_SRC = 4,
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] trig_i,
  input  logic [N_SRC-1:0] src_mask_i,
  input  logic [CNT_W-1:0] start_i,
  input  logic [CNT_W-1:0] stop_i,
  input  logic             negate_i,
  input  logic             retrig_en_i,
  output logic             gate_o
);
  logic             trig_pulse;
  logic             gate_active;
  gate_state_e      tmr_state;
  logic [CNT_W-1:0] tmr_cnt, tmr_start, tmr_stop;
  logic             tmr_retrig;

  gate_trig_edge #(.N_SRC(N_SRC)) u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .trig_i  (trig_i),
    .mask_i  (src_mask_i),
    .pulse_o (trig_pulse)
  );

  gate_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pulse_i     (trig_pulse),
    .start_i     (start_i),
    .stop_i      (stop_i),
    .retrig_en_i (retrig_en_i),
    .active_o    (gate_active),
    .state_o     (tmr_state),
    .cnt_o       (tmr_cnt),
    .start_q_o   (tmr_start),
    .stop_q_o    (tmr_stop),
    .retrig_q_o  (tmr_retrig)
  );

  assign gate_o = gate_active ^ negate_i;
endmodule

// File: rtl/gate_gen_chk.sv
module gate_gen_chk
  import gate_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             negate_i,
  input logic             gate_o,
  input logic             pulse,
  input gate_state_e      state,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] start_q,
  input logic [CNT_W-1:0] stop_q,
  input logic             retrig_q
);
  assert_delay_closed_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_DELAY) |-> (gate_o == negate_i));

  assert_cnt_below_stop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state != ST_IDLE) |-> (cnt < stop_q));

  assert_idle_no_trig_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IDLE && !pulse) |=> (gate_o == negate_i));

  assert_busy_ignore_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state != ST_IDLE && !retrig_q) |=>
      (state == ST_IDLE || cnt == CNT_W'($past(cnt) + 1'b1)));

  assert_reload_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state != ST_IDLE && retrig_q && pulse) |=>
      (state == ST_ACTIVE && cnt == $past(start_q)));

  assert_cfg_held_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state != ST_IDLE && $past(state) != ST_IDLE) |->
      ($stable(start_q) && $stable(stop_q) && $stable(retrig_q)));
endmodule

bind gate_gen gate_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .negate_i (negate_i),
  .gate_o   (gate_o),
  .pulse    (trig_pulse),
  .state    (tmr_state),
  .cnt      (tmr_cnt),
  .start_q  (tmr_start),
  .stop_q   (tmr_stop),
  .retrig_q (tmr_retrig)
);

// File: tb/gate_gen_bench.sv
`timescale 1ns/1ps
module gate_gen_bench;
  localparam int N_SRC = 4;
  localparam int CNT_W = 16;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [N_SRC-1:0] trig_i = '0;
  logic [N_SRC-1:0] src_mask_i = '0;
  logic [CNT_W-1:0] start_i = '0;
  logic [CNT_W-1:0] stop_i = '0;
  logic             negate_i = 1'b0;
  logic             retrig_en_i = 1'b0;
  logic             gate_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2 clk_i = ~clk_i;

  gate_gen #(.N_SRC(N_SRC), .CNT_W(CNT_W)) u_gate_gen (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .trig_i      (trig_i),
    .src_mask_i  (src_mask_i),
    .start_i     (start_i),
    .stop_i      (stop_i),
    .negate_i    (negate_i),
    .retrig_en_i (retrig_en_i),
    .gate_o      (gate_o)
  );

  always @(posedge clk_i) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog expired act=%0d exp=<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic check(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0b exp=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // One trigger on line src at edge k; optional second trigger at edge k+r (r>=2).
  task automatic run(input int st, input int sp, input bit neg, input bit rtg,
                     input int r, input int src, input bit hold, input bit chg,
                     input string req);
    bit fire;
    int last;
    bit hi;
    fire = src_mask_i[src];
    @(negedge clk_i);
    start_i = CNT_W'(st); stop_i = CNT_W'(sp);
    negate_i = neg; retrig_en_i = rtg;
    @(negedge clk_i);
    check(gate_o, neg, {req, " idle before trigger"});
    trig_i[src] = 1'b1;
    last = 2 * sp + 4;
    for (int t = 0; t <= last; t++) begin
      @(negedge clk_i);
      if (!fire || st >= sp) hi = 1'b0;
      else if (rtg && r > 0 && t >= r) hi = (t < r + sp - st);
      else hi = (t >= st && t < sp);
      check(gate_o, hi ^ neg, req);
      if (t == 0 && !hold) trig_i[src] = 1'b0;
      if (t == 0 && chg) begin
        start_i = CNT_W'(st + 3); stop_i = CNT_W'(sp + 9); retrig_en_i = ~rtg;
      end
      if (r > 0 && t == r - 1) trig_i[src] = 1'b1;
      if (r > 0 && t == r) trig_i[src] = 1'b0;
    end
    trig_i = '0;
    @(negedge clk_i);
  endtask

  initial begin
    src_mask_i = 4'b1111;
    #1;
    check(gate_o, 1'b0, "R1 reset level");
    negate_i = 1'b1;
    #1;
    check(gate_o, 1'b1, "R1 R9 reset level inverted");
    negate_i = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(gate_o, 1'b0, "R1 after reset");

    // R4 R5 R6 R9 R11: full single-trigger sweep
    for (int st = 0; st <= 4; st++)
      for (int sp = 0; sp <= 6; sp++)
        for (int n = 0; n <= 1; n++)
          run(st, sp, n[0], 1'b0, 0, (st + sp) % N_SRC, 1'b0, 1'b0,
              st >= sp ? "R6 empty window" : (st == 0 ? "R5 zero start" : "R4 R9 R11 window"));

    // R7 R8: second trigger at every offset within the window
    for (int st = 1; st <= 3; st++)
      for (int sp = st + 1; sp <= 5; sp++)
        for (int r = 2; r < sp; r++) begin
          run(st, sp, 1'b0, 1'b1, r, 0, 1'b0, 1'b0, "R8 retrigger reload");
          run(st, sp, 1'b1, 1'b0, r, 1, 1'b0, 1'b0, "R7 busy trigger ignored");
        end

    // R2: only masked-off lines toggled
    src_mask_i = 4'b0101;
    run(1, 4, 1'b0, 1'b0, 0, 1, 1'b0, 1'b0, "R2 masked line 1");
    run(0, 3, 1'b1, 1'b0, 0, 3, 1'b0, 1'b0, "R2 masked line 3");
    run(1, 4, 1'b0, 1'b0, 0, 2, 1'b0, 1'b0, "R2 enabled line 2");
    src_mask_i = 4'b1111;

    // R3: level held high through and after window, retrigger on
    run(1, 4, 1'b0, 1'b1, 0, 0, 1'b1, 1'b0, "R3 held level single pulse");
    run(0, 2, 1'b0, 1'b1, 0, 2, 1'b1, 1'b0, "R3 held level zero start");

    // R10: configuration changed right after trigger
    run(2, 5, 1'b0, 1'b0, 0, 0, 1'b0, 1'b1, "R10 cfg change mid pulse");
    run(1, 4, 1'b0, 1'b1, 3, 1, 1'b0, 1'b1, "R10 retrigger latched");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule